// File: doc/BRIEF.md
# Transceiver Control Register Bank

This block holds the byte-wide control and status registers of a USB 2.0 transceiver. A link controller reaches it over a simple synchronous register bus. The bus has a 6-bit address, separate read and write strobes, and 8-bit data in each direction. Every writable register answers at three consecutive addresses. The lowest of the three overwrites the register. The next ORs the write data into it. The last clears each bit that is 1 in the write data. A read at any of the three returns the register.

Besides the plain control bytes, the bank holds several other kinds of register:

- four constant identification bytes;
- a live status byte for the host-disconnect input;
- an interrupt latch that a read clears;
- a debug byte that mirrors the live line state;
- a scratch byte.

The transceiver reset bit raises a one-cycle reset request toward the core. The bit clears itself when the core reports completion. The suspend bit is forced back to 1 when the transceiver leaves low-power mode. The control fields drive dedicated output pins.

Top module: `xcvr_reg_bank`

## Requirements
- R1: For each writable register at base address B, a write to B stores the data, a write to B+1 ORs the data into the register, and a write to B+2 clears every bit that is 1 in the data. A read at B, B+1 or B+2 returns the register. Bits that are not implemented always read 0.
- R2: The bases are: function control 04h, interface control 07h, pulldown control 0Ah, rising interrupt enable 0Dh, falling interrupt enable 10h, scratch 16h. The other fixed addresses are: status 13h, latch 14h, debug 15h.
- R3: Addresses 00h, 01h, 02h and 03h read 51h, 04h, 10h and 13h, and writes to them have no effect.
- R4: After reset the registers read as follows: function control 41h, interface control 00h, pulldown control 06h, both interrupt enables 01h, scratch 00h, latch 00h. The implemented bits are: function control 6:0; interface control bits 3 and 7; pulldown control bits 1 and 2; bit 0 of each interrupt enable; all 8 bits of scratch.
- R5: Function control bit 5 is the transceiver reset. When it changes from 0 to 1, `coreRstReq` is high for exactly the next cycle. The bit reads 0 from the cycle after `coreRstDone` is high. If `coreRstDone` coincides with a write, the clear wins.
- R6: A cycle with `lowPowerExit` high sets function control bit 6 (active-low suspend) to 1 on the next edge. This overrides a clearing write in the same cycle.
- R7: `serialClkOn` is 1 only when interface control bit 3 is 1 and function control bit 6 is 1. While bit 6 is 0, interface bit 3 has no effect on the output.
- R8: A read at 13h returns the live `hostDisc` in bit 0. A read at 15h returns the live `lineState` in bits 1:0. Both are sampled in the read cycle.
- R9: Host mode means pulldown control bits 1 and 2 are both 1. In host mode, a 0→1 change of `hostDisc` sets the latch (14h bit 0) when rising-enable bit 0 is 1, and a 1→0 change sets it when falling-enable bit 0 is 1. A read at 14h returns the latch and clears it. If an event and the read fall in the same cycle, the latch stays set. `intPending` shows the latch.
- R10: Addresses 19h to 3Fh read 00h. Writes to any read-only or unmapped address (00h–03h, 13h–15h, 19h–3Fh) change no register.
- R11: `regRdData` takes the addressed value at the edge that ends a cycle with `regRdEn` high. It holds that value when no read is made.
- R12: The outputs mirror the register fields:
  - `xcvrSel` is function control bits 1:0;
  - `termSel` is bit 2;
  - `opMode` is bits 4:3;
  - `suspendN` is bit 6;
  - `protectDis` is interface control bit 7;
  - `dpPullDn` and `dmPullDn` are pulldown control bits 1 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 6 | Register address |
| regWrEn | input | 1 | Write strobe |
| regRdEn | input | 1 | Read strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Registered read data |
| hostDisc | input | 1 | Host-disconnect comparator level |
| lineState | input | 2 | Live line state |
| lowPowerExit | input | 1 | Pulse when low-power mode ends |
| coreRstDone | input | 1 | Core reset completed |
| coreRstReq | output | 1 | One-cycle core reset request |
| intPending | output | 1 | Interrupt latch state |
| xcvrSel | output | 2 | Transceiver speed select |
| termSel | output | 1 | Termination select |
| opMode | output | 2 | Transmit encoding mode |
| suspendN | output | 1 | Active-low suspend |
| serialClkOn | output | 1 | Serial-mode clock powered |
| protectDis | output | 1 | Bus protect pull disable |
| dpPullDn | output | 1 | D+ pulldown enable |
| dmPullDn | output | 1 | D– pulldown enable |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle. They also assume that `hostDisc` is low while reset is held, so no edge is seen at the first cycle after reset. The bench drives at most one strobe in any cycle, both in the directed sections and in the random section, and it keeps `hostDisc` at 0 during reset. `coreRstDone` and `lowPowerExit` are driven as short pulses at arbitrary points. This covers both the case where they coincide with writes to function control and the case where they come alone.

// File: rtl/xrb_pkg.sv
package xrb_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int NUM_WR = 6;
  localparam int ID_N   = 4;
  localparam int ID_W   = $clog2(ID_N);
  localparam int LS_W   = 2;

  localparam int IDX_FUNC  = 0;
  localparam int IDX_IFACE = 1;
  localparam int IDX_OTG   = 2;
  localparam int IDX_IENR  = 3;
  localparam int IDX_IENF  = 4;
  localparam int IDX_SCR   = 5;

  localparam int FC_RST_BIT  = 5;
  localparam int FC_SUSP_BIT = 6;
  localparam int IC_CLK_BIT  = 3;
  localparam int IC_PROT_BIT = 7;
  localparam int OC_DP_BIT   = 1;
  localparam int OC_DM_BIT   = 2;

  localparam logic [ADDR_W-1:0] STAT_ADDR  = 6'h13;
  localparam logic [ADDR_W-1:0] LATCH_ADDR = 6'h14;
  localparam logic [ADDR_W-1:0] DBG_ADDR   = 6'h15;

  typedef enum logic [1:0] {OP_NONE, OP_WRITE, OP_SET, OP_CLEAR} wrOp_e;

  typedef struct packed {
    logic [NUM_WR-1:0] wrHit;
    wrOp_e             wrOp;
    logic              rdEn;
    logic [NUM_WR-1:0] rdHit;
    logic              idHit;
    logic [ID_W-1:0]   idSel;
    logic              statHit;
    logic              latchHit;
    logic              dbgHit;
  } regStrobe_t;

  function automatic logic [ADDR_W-1:0] wrBase(input int k);
    case (k)
      IDX_FUNC:  return 6'h04;
      IDX_IFACE: return 6'h07;
      IDX_OTG:   return 6'h0A;
      IDX_IENR:  return 6'h0D;
      IDX_IENF:  return 6'h10;
      default:   return 6'h16;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] wrMask(input int k);
    case (k)
      IDX_FUNC:  return 8'h7F;
      IDX_IFACE: return 8'h88;
      IDX_OTG:   return 8'h06;
      IDX_IENR:  return 8'h01;
      IDX_IENF:  return 8'h01;
      default:   return 8'hFF;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] rstVal(input int k);
    case (k)
      IDX_FUNC:  return 8'h41;
      IDX_IFACE: return 8'h00;
      IDX_OTG:   return 8'h06;
      IDX_IENR:  return 8'h01;
      IDX_IENF:  return 8'h01;
      default:   return 8'h00;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] idByte(input logic [ID_W-1:0] s);
    case (s)
      2'd0:    return 8'h51;
      2'd1:    return 8'h04;
      2'd2:    return 8'h10;
      default: return 8'h13;
    endcase
  endfunction
endpackage

// File: rtl/xrb_ctrl.sv
module xrb_ctrl
  import xrb_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output regStrobe_t        strb
);
  logic [ADDR_W-1:0] off;

  always_comb begin
    strb = '0;
    off = '0;
    strb.rdEn = regRdEn;
    for (int k = 0; k < NUM_WR; k++) begin
      if (regAddr >= wrBase(k) && regAddr <= wrBase(k) + 6'd2) begin
        strb.rdHit[k] = 1'b1;
        off = regAddr - wrBase(k);
        if (regWrEn) begin
          strb.wrHit[k] = 1'b1;
          case (off)
            6'd0:    strb.wrOp = OP_WRITE;
            6'd1:    strb.wrOp = OP_SET;
            default: strb.wrOp = OP_CLEAR;
          endcase
        end
      end
    end
    strb.idHit    = (regAddr < ADDR_W'(ID_N));
    strb.idSel    = regAddr[ID_W-1:0];
    strb.statHit  = (regAddr == STAT_ADDR);
    strb.latchHit = (regAddr == LATCH_ADDR);
    strb.dbgHit   = (regAddr == DBG_ADDR);
  end
endmodule

// File: rtl/xrb_datapath.sv
module xrb_datapath
  import xrb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              hostDisc,
  input  logic [LS_W-1:0]   lineState,
  input  logic              lowPowerExit,
  input  logic              coreRstDone,
  output logic [DATA_W-1:0] rdData,
  output logic              coreRstReq,
  output logic              intPending,
  output logic [1:0]        xcvrSel,
  output logic              termSel,
  output logic [1:0]        opMode,
  output logic              suspendN,
  output logic              serialClkOn,
  output logic              protectDis,
  output logic              dpPullDn,
  output logic              dmPullDn
);
  logic [DATA_W-1:0] regVal [NUM_WR];
  logic [DATA_W-1:0] rdNext;
  logic hostDiscQ, rstBitQ, latchQ, hostMode, discEvent;

  for (genvar k = 0; k < NUM_WR; k++) begin : g_reg
    logic [DATA_W-1:0] q, nxt;
    always_comb begin
      nxt = q;
      if (strb.wrHit[k]) begin
        case (strb.wrOp)
          OP_WRITE: nxt = wrData & wrMask(k);
          OP_SET:   nxt = (q | wrData) & wrMask(k);
          OP_CLEAR: nxt = q & ~wrData;
          default:  nxt = q;
        endcase
      end
      if (k == IDX_FUNC) begin
        if (coreRstDone)  nxt[FC_RST_BIT]  = 1'b0;
        if (lowPowerExit) nxt[FC_SUSP_BIT] = 1'b1;
      end
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= rstVal(k);
      else       q <= nxt;
    end
    assign regVal[k] = q;
  end

  assign hostMode  = regVal[IDX_OTG][OC_DP_BIT] & regVal[IDX_OTG][OC_DM_BIT];
  assign discEvent = hostMode &
                     (( hostDisc & ~hostDiscQ & regVal[IDX_IENR][0]) |
                      (~hostDisc &  hostDiscQ & regVal[IDX_IENF][0]));

  always_comb begin
    rdNext = '0;
    if (strb.idHit) rdNext = idByte(strb.idSel);
    for (int k = 0; k < NUM_WR; k++)
      if (strb.rdHit[k]) rdNext = regVal[k];
    if (strb.statHit)  rdNext = {{(DATA_W-1){1'b0}}, hostDisc};
    if (strb.latchHit) rdNext = {{(DATA_W-1){1'b0}}, latchQ};
    if (strb.dbgHit)   rdNext = {{(DATA_W-LS_W){1'b0}}, lineState};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData    <= '0;
      hostDiscQ <= 1'b0;
      rstBitQ   <= 1'b0;
      latchQ    <= 1'b0;
    end else begin
      if (strb.rdEn) rdData <= rdNext;
      hostDiscQ <= hostDisc;
      rstBitQ   <= regVal[IDX_FUNC][FC_RST_BIT];
      if (discEvent)                         latchQ <= 1'b1;
      else if (strb.rdEn && strb.latchHit)   latchQ <= 1'b0;
    end
  end

  assign coreRstReq  = regVal[IDX_FUNC][FC_RST_BIT] & ~rstBitQ;
  assign intPending  = latchQ;
  assign xcvrSel     = regVal[IDX_FUNC][1:0];
  assign termSel     = regVal[IDX_FUNC][2];
  assign opMode      = regVal[IDX_FUNC][4:3];
  assign suspendN    = regVal[IDX_FUNC][FC_SUSP_BIT];
  assign serialClkOn = regVal[IDX_IFACE][IC_CLK_BIT] & regVal[IDX_FUNC][FC_SUSP_BIT];
  assign protectDis  = regVal[IDX_IFACE][IC_PROT_BIT];
  assign dpPullDn    = regVal[IDX_OTG][OC_DP_BIT];
  assign dmPullDn    = regVal[IDX_OTG][OC_DM_BIT];
endmodule

// File: rtl/xcvr_reg_bank.sv
module xcvr_reg_bank
  import xrb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              hostDisc,
  input  logic [LS_W-1:0]   lineState,
  input  logic              lowPowerExit,
  input  logic              coreRstDone,
  output logic              coreRstReq,
  output logic              intPending,
  output logic [1:0]        xcvrSel,
  output logic              termSel,
  output logic [1:0]        opMode,
  output logic              suspendN,
  output logic              serialClkOn,
  output logic              protectDis,
  output logic              dpPullDn,
  output logic              dmPullDn
);
  regStrobe_t strb;

  xrb_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .strb    (strb)
  );

  xrb_datapath u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .wrData       (regWrData),
    .hostDisc     (hostDisc),
    .lineState    (lineState),
    .lowPowerExit (lowPowerExit),
    .coreRstDone  (coreRstDone),
    .rdData       (regRdData),
    .coreRstReq   (coreRstReq),
    .intPending   (intPending),
    .xcvrSel      (xcvrSel),
    .termSel      (termSel),
    .opMode       (opMode),
    .suspendN     (suspendN),
    .serialClkOn  (serialClkOn),
    .protectDis   (protectDis),
    .dpPullDn     (dpPullDn),
    .dmPullDn     (dmPullDn)
  );
endmodule

// File: rtl/xrb_checker.sv
module xrb_checker (
  input logic       clk,
  input logic       rstN,
  input logic [5:0] regAddr,
  input logic       regRdEn,
  input logic [7:0] regRdData,
  input logic       lowPowerExit,
  input logic       coreRstReq,
  input logic       intPending,
  input logic       suspendN,
  input logic       serialClkOn,
  input logic       dpPullDn,
  input logic       dmPullDn
);
  assert_rst_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    coreRstReq |=> !coreRstReq);

  assert_lp_exit_R6: assert property (@(posedge clk) disable iff (!rstN)
    lowPowerExit |=> suspendN);

  assert_clk_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    !suspendN |-> !serialClkOn);

  assert_latch_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == 6'h14 && !(dpPullDn && dmPullDn)) |=> !intPending);

  assert_rsvd_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr >= 6'h19) |=> regRdData == 8'h00);

  assert_id_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == 6'h00) |=> regRdData == 8'h51);

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |=> $stable(regRdData));
endmodule

bind xcvr_reg_bank xrb_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .regAddr      (regAddr),
  .regRdEn      (regRdEn),
  .regRdData    (regRdData),
  .lowPowerExit (lowPowerExit),
  .coreRstReq   (coreRstReq),
  .intPending   (intPending),
  .suspendN     (suspendN),
  .serialClkOn  (serialClkOn),
  .dpPullDn     (dpPullDn),
  .dmPullDn     (dmPullDn)
);

// File: tb/tb_xcvr_reg_bank.sv
`timescale 1ns/1ps
module tb_xcvr_reg_bank;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] regAddr = '0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic hostDisc = 1'b0;
  logic [1:0] lineState = '0;
  logic lowPowerExit = 1'b0, coreRstDone = 1'b0;
  logic coreRstReq, intPending, termSel, suspendN, serialClkOn, protectDis, dpPullDn, dmPullDn;
  logic [1:0] xcvrSel, opMode;

  always #4 clk = ~clk;

  xcvr_reg_bank dut (.*);

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  string curReq = "R4";

  logic [7:0] mFc, mIc, mOc, mEr, mEf, mSc, mRd;
  logic mLat, mHdPrev, mPulse;

  function automatic logic [7:0] modelRead(input logic [5:0] a);
    if (a >= 6'h04 && a <= 6'h06) return mFc;
    if (a >= 6'h07 && a <= 6'h09) return mIc;
    if (a >= 6'h0A && a <= 6'h0C) return mOc;
    if (a >= 6'h0D && a <= 6'h0F) return mEr;
    if (a >= 6'h10 && a <= 6'h12) return mEf;
    if (a >= 6'h16 && a <= 6'h18) return mSc;
    case (a)
      6'h00: return 8'h51;
      6'h01: return 8'h04;
      6'h02: return 8'h10;
      6'h03: return 8'h13;
      6'h13: return {7'b0, hostDisc};
      6'h14: return {7'b0, mLat};
      6'h15: return {6'b0, lineState};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] applyOp(input logic [7:0] cur, input int kind,
                                         input logic [7:0] d, input logic [7:0] msk);
    if (kind == 0) return d & msk;
    if (kind == 1) return (cur | d) & msk;
    return cur & ~d;
  endfunction

  task automatic modelWrite(input logic [5:0] a, input logic [7:0] d);
    if (a >= 6'h04 && a <= 6'h06) mFc = applyOp(mFc, int'(a - 6'h04), d, 8'h7F);
    else if (a >= 6'h07 && a <= 6'h09) mIc = applyOp(mIc, int'(a - 6'h07), d, 8'h88);
    else if (a >= 6'h0A && a <= 6'h0C) mOc = applyOp(mOc, int'(a - 6'h0A), d, 8'h06);
    else if (a >= 6'h0D && a <= 6'h0F) mEr = applyOp(mEr, int'(a - 6'h0D), d, 8'h01);
    else if (a >= 6'h10 && a <= 6'h12) mEf = applyOp(mEf, int'(a - 6'h10), d, 8'h01);
    else if (a >= 6'h16 && a <= 6'h18) mSc = applyOp(mSc, int'(a - 6'h16), d, 8'hFF);
  endtask

  task automatic modelReset();
    mFc = 8'h41; mIc = 8'h00; mOc = 8'h06; mEr = 8'h01; mEf = 8'h01; mSc = 8'h00;
    mRd = 8'h00; mLat = 1'b0; mHdPrev = 1'b0; mPulse = 1'b0;
  endtask

  task automatic modelStep();
    logic oldRst, ev;
    oldRst = mFc[5];
    ev = mOc[1] && mOc[2] &&
         ((hostDisc && !mHdPrev && mEr[0]) || (!hostDisc && mHdPrev && mEf[0]));
    if (regRdEn) mRd = modelRead(regAddr);
    if (regWrEn) modelWrite(regAddr, regWrData);
    if (coreRstDone) mFc[5] = 1'b0;
    if (lowPowerExit) mFc[6] = 1'b1;
    if (ev) mLat = 1'b1;
    else if (regRdEn && regAddr == 6'h14) mLat = 1'b0;
    mHdPrev = hostDisc;
    mPulse = mFc[5] && !oldRst;
  endtask

  task automatic cmp(input string req, input string what, input int act, input int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    vectors++;
    cmp(curReq, "regRdData", regRdData, mRd);
    cmp("R5", "coreRstReq", coreRstReq, mPulse);
    cmp("R9", "intPending", intPending, mLat);
    cmp("R6", "suspendN", suspendN, mFc[6]);
    cmp("R7", "serialClkOn", serialClkOn, mIc[3] & mFc[6]);
    cmp("R12", "xcvrSel", xcvrSel, mFc[1:0]);
    cmp("R12", "termSel", termSel, mFc[2]);
    cmp("R12", "opMode", opMode, mFc[4:3]);
    cmp("R12", "protectDis", protectDis, mIc[7]);
    cmp("R12", "dpPullDn", dpPullDn, mOc[1]);
    cmp("R12", "dmPullDn", dmPullDn, mOc[2]);
  endtask

  // one bus cycle; side inputs (hostDisc, lineState, pulses) set by caller
  task automatic cyc(input logic [5:0] a, input bit wr, input bit rd, input logic [7:0] d);
    regAddr = a; regWrEn = wr; regRdEn = rd; regWrData = d;
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compareAll();
    regWrEn = 1'b0; regRdEn = 1'b0;
    lowPowerExit = 1'b0; coreRstDone = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d); cyc(a, 1, 0, d); endtask
  task automatic rd(input logic [5:0] a); cyc(a, 0, 1, 8'h00); endtask
  task automatic idle(); cyc(6'h00, 0, 0, 8'h00); endtask

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    curReq = "R4";
    compareAll();
    for (int a = 0; a < 64; a++) rd(6'(a));

    curReq = "R1";
    wr(6'h16, 8'hA5); rd(6'h16);
    wr(6'h17, 8'h0F); rd(6'h17);
    wr(6'h18, 8'h81); rd(6'h18);
    wr(6'h07, 8'hFF); rd(6'h08);
    wr(6'h09, 8'h80); rd(6'h07);
    wr(6'h0E, 8'hFE); rd(6'h0D);

    curReq = "R2";
    wr(6'h04, 8'hFF); rd(6'h05);
    wr(6'h06, 8'h3F); rd(6'h04);
    wr(6'h0C, 8'h02); rd(6'h0B);
    wr(6'h0B, 8'h02); rd(6'h0A);
    wr(6'h11, 8'h00); rd(6'h12);

    curReq = "R12";
    wr(6'h04, 8'h5A); idle();
    wr(6'h04, 8'h47); idle();

    curReq = "R3";
    wr(6'h00, 8'hFF); wr(6'h03, 8'h00); rd(6'h00); rd(6'h03);

    curReq = "R10";
    wr(6'h13, 8'hFF); wr(6'h14, 8'hFF); wr(6'h15, 8'hFF); wr(6'h20, 8'hFF); wr(6'h3F, 8'hFF);
    rd(6'h19); rd(6'h2E); rd(6'h3F); rd(6'h16); rd(6'h04);

    curReq = "R5";
    wr(6'h05, 8'h20); idle(); idle(); rd(6'h04);
    coreRstDone = 1'b1; idle(); rd(6'h04);
    wr(6'h05, 8'h20); idle();
    coreRstDone = 1'b1; wr(6'h05, 8'h20); rd(6'h04);

    curReq = "R6";
    wr(6'h06, 8'h40); rd(6'h04);
    lowPowerExit = 1'b1; idle(); rd(6'h04);
    lowPowerExit = 1'b1; wr(6'h06, 8'h40); rd(6'h04);

    curReq = "R7";
    wr(6'h08, 8'h08); idle();
    wr(6'h06, 8'h40); idle();
    wr(6'h05, 8'h40); idle();

    curReq = "R8";
    hostDisc = 1'b1; lineState = 2'b10; rd(6'h13); rd(6'h15);
    hostDisc = 1'b0; lineState = 2'b01; rd(6'h13); rd(6'h15);
    rd(6'h14);

    curReq = "R9";
    wr(6'h0A, 8'h06); wr(6'h0D, 8'h01); wr(6'h10, 8'h01); rd(6'h14);
    hostDisc = 1'b1; idle(); rd(6'h14); rd(6'h14);
    hostDisc = 1'b0; idle(); rd(6'h14);
    wr(6'h0F, 8'h01);
    hostDisc = 1'b1; idle(); rd(6'h14);
    hostDisc = 1'b0; rd(6'h14); rd(6'h14);
    hostDisc = 1'b1; rd(6'h14);
    wr(6'h0E, 8'h01);
    hostDisc = 1'b0; idle();
    hostDisc = 1'b1; rd(6'h14); rd(6'h14);
    wr(6'h0C, 8'h04);
    hostDisc = 1'b0; idle(); rd(6'h14);
    hostDisc = 1'b1; idle(); rd(6'h14);
    wr(6'h0B, 8'h06);

    curReq = "R11";
    for (int i = 0; i < 600; i++) begin
      logic [5:0] a;
      int op;
      a = 6'($urandom_range(0, 26));
      if ($urandom_range(0, 9) == 0) a = 6'($urandom);
      op = $urandom_range(0, 2);
      hostDisc = ($urandom_range(0, 3) == 0) ? ~hostDisc : hostDisc;
      lineState = 2'($urandom);
      lowPowerExit = ($urandom_range(0, 15) == 0);
      coreRstDone = ($urandom_range(0, 7) == 0);
      cyc(a, op == 1, op == 2, 8'($urandom));
    end

    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule